// File: doc/BRIEF.md
# Dual-Channel Synchronous Rectifier Interlock

This block sits between two synchronous-rectifier channel controllers and their gate drivers. Each channel hands it three signals, all synchronous to the block clock: a turn-on request that has already been qualified and debounced, a gate-off event pulse from its turn-off comparator, and an arming flag that is high while that channel's drain-source voltage sits above the positive arming threshold. The block returns one registered gate enable per channel.

The interlock allows a channel to conduct only while the opposite channel's switch is clearly blocking. It allows a single turn-on per conduction window, hands the turn strictly to the other channel after each turn-off, and keeps the two channels' currents balanced. When a channel lets its whole window go by without conducting, the other channel sits out its next window. The turn belongs to no channel until the first turn-off, so either one may go first.

A channel's conduction window is the time the opposite channel's arming flag is high. Channel 0 has priority when both channels are eligible in the same cycle. This priority is set by a parameter.

Top module: `srx_interlock`

## Requirements
- R1: Synchronous active-high reset clears both gate enables and leaves the turn open, so that the first eligible channel of either index is granted.
- R2: A gate enable rises only at a clock edge that samples the channel's request high and the opposite channel's arming flag high. An enabled gate is dropped at the first edge that samples the opposite arming flag low.
- R3: The two gate enables are never high in the same cycle.
- R4: An enabled gate drops at the clock edge that samples its own gate-off event high.
- R5: After a channel's gate drops, further requests from that channel are not granted until the other channel's gate has risen and fallen. This includes requests caused by the body-diode step that follows the turn-off.
- R6: Turns alternate. After one channel's gate drops, only the other channel may be granted next, unless R7 intervenes.
- R7: A channel holding the turn misses its window when the opposite arming flag rises and then falls with no grant to it in between. The opposite channel is then barred from turning on for the whole of its next window.
- R8: When the barred window ends (the missing channel's own arming flag falls), the bar is lifted and the turn returns to the channel that missed. The barred channel's unused window does not count as a miss of its own.
- R9: When both channels are eligible in the same cycle, the channel selected by parameter PREF (default 0) is granted and the other is not.
- R10: A request is not granted while either gate is enabled, or in a cycle whose own gate-off event is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 2 | Qualified turn-on request per channel (bit 0 = channel 0) |
| goff | input | 2 | Gate-off event per channel, one cycle or longer |
| arm | input | 2 | High while that channel's drain-source voltage is above the arming threshold |
| gate | output | 2 | Registered gate enable per channel |

## Verification
The hardest situation to reach from the ports is the miss-and-skip chain. A window must open and close while the channel that holds the turn never requests. The opposite channel must then request during its very next window and be refused. After that window closes, the original channel must win again. The directed stimulus builds this chain in a fixed order: it opens and closes channel 0's window with requests held low, asks for channel 1 throughout channel 1's window, then re-arms channel 0. A randomized phase with sparse gate-off pulses and slowly changing arming flags then checks overlap and arming dependence over thousands of cycles.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int NCH = 2;

  // one-hot mask of the channel opposite to idx
  function automatic logic [NCH-1:0] peer_mask(input int idx);
    logic [NCH-1:0] m;
    m = '0;
    m[NCH-1-idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/srx_window.sv
// Tracks one channel's conduction window (opposite arming flag high)
// and reports a miss when the window closes with no grant to it.
module srx_window (
  input  logic clk,
  input  logic rst,
  input  logic peer_arm,
  input  logic grant,
  input  logic gate_on,
  input  logic has_turn,
  output logic win_fall,
  output logic miss
);
  logic arm_q, open_q, got_q, rise;

  assign rise     = peer_arm & ~arm_q;
  assign win_fall = ~peer_arm & arm_q;
  assign miss     = win_fall & open_q & ~(got_q | grant | gate_on) & has_turn;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      open_q <= 1'b0;
      got_q  <= 1'b0;
    end else begin
      arm_q <= peer_arm;
      if (rise) begin
        open_q <= 1'b1;
        got_q  <= grant | gate_on;
      end else begin
        got_q <= got_q | grant | gate_on;
        if (win_fall) open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_gate.sv
// Registered gate enable for one channel.
module srx_gate (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic goff,
  input  logic peer_arm,
  output logic gate_on,
  output logic drop
);
  assign drop = gate_on & (goff | ~peer_arm);

  always_ff @(posedge clk) begin
    if (rst)        gate_on <= 1'b0;
    else if (drop)  gate_on <= 1'b0;
    else if (grant) gate_on <= 1'b1;
  end

  // R4
  off_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_on && goff) |=> !gate_on);
endmodule

// File: rtl/srx_interlock.sv
module srx_interlock #(
  parameter int PREF = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic [1:0] goff,
  input  logic [1:0] arm,
  output logic [1:0] gate
);
  import srx_pkg::*;
  localparam int ALT = NCH - 1 - PREF;

  logic [NCH-1:0] turn_ok, skip, elig, grant, drop, win_fall, miss, has_turn;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      localparam int P = NCH - 1 - g;
      assign elig[g] = req[g] & arm[P] & turn_ok[g] & ~skip[g]
                     & ~(|gate) & ~goff[g];
      assign has_turn[g] = turn_ok[g] & ~skip[g];

      srx_gate u_gate (
        .clk(clk), .rst(rst), .grant(grant[g]), .goff(goff[g]),
        .peer_arm(arm[P]), .gate_on(gate[g]), .drop(drop[g]));

      srx_window u_win (
        .clk(clk), .rst(rst), .peer_arm(arm[P]), .grant(grant[g]),
        .gate_on(gate[g]), .has_turn(has_turn[g]),
        .win_fall(win_fall[g]), .miss(miss[g]));
    end
  endgenerate

  always_comb begin
    grant       = '0;
    grant[PREF] = elig[PREF];
    grant[ALT]  = elig[ALT] & ~elig[PREF];
  end

  // turn token and skip penalty; later statements take precedence
  always_ff @(posedge clk) begin
    if (rst) begin
      turn_ok <= '1;
      skip    <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (win_fall[i] && skip[i]) begin
          skip[i] <= 1'b0;
          turn_ok <= peer_mask(i);
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (miss[i]) begin
          skip[NCH-1-i] <= 1'b1;
          turn_ok       <= peer_mask(i);
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (drop[i]) turn_ok <= peer_mask(i);
      end
    end
  end

  // ---------------- assertions ----------------
  logic       last_vld;
  logic       last_ch;
  always_ff @(posedge clk) begin
    if (rst) begin
      last_vld <= 1'b0;
      last_ch  <= 1'b0;
    end else if (gate[0] && !gate[1]) begin
      last_vld <= 1'b1;
      last_ch  <= 1'b0;
    end else if (gate[1] && !gate[0]) begin
      last_vld <= 1'b1;
      last_ch  <= 1'b1;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate[0] && gate[1]));

  // R2
  arm_ch0_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[0]) |-> $past(arm[1]));
  // R2
  arm_ch1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[1]) |-> $past(arm[0]));

  // R5
  retrig_ch0_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[0]) |-> !(last_vld && last_ch == 1'b0));
  // R5
  retrig_ch1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[1]) |-> !(last_vld && last_ch == 1'b1));

  // R7
  skip_ch0_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[0]) |-> !$past(skip[0]));
  // R7
  skip_ch1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate[1]) |-> !$past(skip[1]));
endmodule

// File: tb/sim_srx_interlock.sv
`timescale 1ns/1ps
module sim_srx_interlock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req = '0, goff = '0, arm = '0;
  logic [1:0] gate;

  always #5 clk = ~clk;

  srx_interlock u0 (.clk(clk), .rst(rst), .req(req), .goff(goff),
                    .arm(arm), .gate(gate));

  typedef struct {
    logic [1:0] g;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   rnd_on = 1'b0;
  bit   done   = 1'b0;

  // apply one cycle of inputs and queue the gate value expected after the edge
  task automatic drv(input logic [1:0] rq, input logic [1:0] of,
                     input logic [1:0] am, input logic [1:0] eg,
                     input string tag);
    @(negedge clk);
    req = rq; goff = of; arm = am;
    q.push_back('{eg, tag});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; goff = '0; arm = '0;
    q.push_back('{2'b00, "R1"});
    @(negedge clk);
    rst = 1'b0;
    q.push_back('{2'b00, "R1"});
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (gate !== it.g) begin
          errors++;
          $display("FAIL %s: gate=%b expected %b at %0t", it.tag, gate, it.g, $time);
        end
      end
      if (rnd_on) begin
        checks++;
        if (gate[0] && gate[1]) begin
          errors++;
          $display("FAIL R3: gate=%b expected no overlap", gate);
        end
        checks++;
        if ((gate[0] && !arm[1]) || (gate[1] && !arm[0])) begin
          errors++;
          $display("FAIL R2: gate=%b arm=%b expected gate only with opposite arm", gate, arm);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: no opposite arming, no grant
    drv(2'b01, 2'b00, 2'b00, 2'b00, "R2");
    drv(2'b01, 2'b00, 2'b10, 2'b01, "R1");   // open turn: channel 0 first
    drv(2'b00, 2'b00, 2'b10, 2'b01, "R2");   // holds while arm stays
    drv(2'b00, 2'b01, 2'b10, 2'b00, "R4");   // gate-off drops it
    drv(2'b01, 2'b00, 2'b10, 2'b00, "R5");   // body-diode retrigger refused
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R5");
    drv(2'b10, 2'b00, 2'b01, 2'b10, "R6");   // channel 1 takes its turn
    drv(2'b11, 2'b00, 2'b01, 2'b10, "R3");   // channel 0 request blocked
    drv(2'b00, 2'b10, 2'b01, 2'b00, "R4");
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R6");
    // miss: channel 0 holds the turn and lets its window pass
    drv(2'b00, 2'b00, 2'b10, 2'b00, "R7");
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R7");
    drv(2'b10, 2'b00, 2'b01, 2'b00, "R7");   // channel 1 barred
    drv(2'b10, 2'b00, 2'b01, 2'b00, "R7");
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R8");
    drv(2'b01, 2'b00, 2'b10, 2'b01, "R8");   // turn back to channel 0
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R2");   // opposite arm falls: drop
    drv(2'b11, 2'b00, 2'b01, 2'b10, "R6");
    drv(2'b00, 2'b10, 2'b01, 2'b00, "R4");
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R4");
    // R10: request together with own gate-off is refused, then granted
    drv(2'b01, 2'b01, 2'b10, 2'b00, "R10");
    drv(2'b01, 2'b00, 2'b10, 2'b01, "R10");
    drv(2'b11, 2'b00, 2'b11, 2'b01, "R10");  // busy gate blocks channel 1
    drv(2'b00, 2'b01, 2'b10, 2'b00, "R4");
    drv(2'b00, 2'b00, 2'b00, 2'b00, "R6");

    // R1: after reset channel 1 may go first
    do_reset();
    drv(2'b10, 2'b00, 2'b01, 2'b10, "R1");
    drv(2'b10, 2'b10, 2'b01, 2'b00, "R4");
    drv(2'b10, 2'b00, 2'b01, 2'b00, "R5");

    // R9: tie after reset goes to channel 0
    do_reset();
    drv(2'b11, 2'b00, 2'b11, 2'b01, "R9");
    drv(2'b11, 2'b00, 2'b11, 2'b01, "R3");
    drv(2'b11, 2'b01, 2'b11, 2'b00, "R4");
    drv(2'b11, 2'b00, 2'b11, 2'b10, "R6");

    // randomized waveforms: overlap and arming invariants (R2, R3)
    do_reset();
    repeat (4) @(negedge clk);
    rnd_on = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) arm[0] = ~arm[0];
      if ($urandom_range(0, 7) == 0) arm[1] = ~arm[1];
      req  = 2'($urandom_range(0, 3));
      goff = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
    end
    @(negedge clk);
    rnd_on = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule